// File: doc/BRIEF.md
# Dual-Processor Mailbox Doorbell Register Bank

This block is a small register bank through which a host processor and an I/O processor pass 32-bit messages and raise doorbell interrupts at each other. It holds four identical banks. One is a legacy global bank at the bottom of the address window. The other three are per-core banks placed at a fixed core base. Every bank has two free message words and two control words. One control word faces the host and one faces the I/O processor. The two control words are cross-wired, so a command written on one side becomes a pending flag on the other.

Both processors share one simple register bus. A master-identity bit on the bus says which processor issues each access. Read data returns combinationally in the same cycle as the request, and writes take effect on the clock edge. The block drives two level-sensitive interrupt lines, one toward each processor. Each line is the OR of every enabled status flag across all four banks.

Control word layout, for both control registers: bits [1:0] are trigger or command bits, bits [3:2] are status flags (write one to clear), and bits [5:4] are the interrupt enables for status bits 2 and 3. Bits [31:6] read as zero.

Top module: `mbx_doorbell`

## Requirements
- R1: Bank windows are 16 bytes wide. The legacy bank is at byte offset 0x000 and the core banks are at 0x400, 0x410 and 0x420. Inside a bank, offset 0x0 is the host message, 0x4 the host control, 0x8 the I/O message and 0xC the I/O control. Address bits [1:0] are ignored.
- R2: Both message registers in every bank are 32-bit storage that either master may write and read back, independently per bank.
- R3: In the host control register, bits [1:0] (command) and bits [5:4] (enable) read back the last value written by either master. Bits [31:6] read as zero.
- R4: A write to the host control register with command bit k (k = 0 or 1) at 1 sets the pending status bit 2+k of the same bank's I/O control register. A write with that bit at 0 sets nothing.
- R5: An I/O-master write to the I/O control register with bit 0 or bit 1 at 1 sets host control status bit 2 or 3 of the same bank. In the I/O control register, bits [1:0] always read as zero.
- R6: Status bits [3:2] in both control registers clear only when a 1 is written to their position. Writing 0 leaves them unchanged. A hardware set in the same cycle as a clear wins.
- R7: Host-master writes to any I/O control register are ignored, and host-master reads of it return zero.
- R8: host_irq is high while any bank has a host status bit set together with its enable. io_irq is high while any bank has an I/O status bit set together with its enable. Both are levels that follow the register state one cycle after the write.
- R9: Reads of unmapped offsets return zero, and writes to them change no register.
- R10: Reset (synchronous, active high) clears every register, and both interrupt lines are low after it.
- R11: rdata carries the addressed word in the same cycle as a request with we low. rdata is zero when there is no request or during a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Bus access request |
| we | input | 1 | 1 = write, 0 = read |
| is_io | input | 1 | Master identity: 1 = I/O processor, 0 = host |
| addr | input | 11 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the request cycle |
| host_irq | output | 1 | Level interrupt toward the host |
| io_irq | output | 1 | Level interrupt toward the I/O processor |

## Verification
The hardest case to observe is a host access to an I/O control register, because a correct design shows nothing at all to the host. If the register is empty, a faulty design that accepts the write looks the same from the ports. The bench therefore first loads the register through the I/O master with enables on and a pending flag raised, so io_irq is high. It then has the host write clearing and trigger patterns at the register. Finally it reads the contents back through the I/O master, checks that the host's own status flags did not change, and confirms that io_irq stayed high.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int MBX_DW      = 32;
    localparam int WORD_LSB    = 2;
    localparam int BANK_LSB    = 4;
    localparam int CTRL_BITS   = 6;

    typedef enum logic [1:0] {
        RG_HMSG = 2'd0,
        RG_HCTL = 2'd1,
        RG_IMSG = 2'd2,
        RG_ICTL = 2'd3
    } reg_e;

    // control word: [5:4] enables, [3:2] status, [1:0] command/trigger
    typedef struct packed {
        logic [1:0] en;
        logic [1:0] stat;
        logic [1:0] cmd;
    } ctrl_t;

    typedef struct packed {
        logic              wr;
        logic              is_io;
        reg_e              idx;
        logic [MBX_DW-1:0] wdata;
    } acc_t;

    function automatic ctrl_t ctrl_of(input logic [CTRL_BITS-1:0] bits);
        return ctrl_t'(bits);
    endfunction

    function automatic logic [MBX_DW-1:0] ctrl_word(input ctrl_t c);
        return {{(MBX_DW-CTRL_BITS){1'b0}}, c};
    endfunction

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int ADDR_W         = 11,
    parameter int NUM_CORE_BANKS = 3,
    parameter int CORE_BASE      = 'h400
) (
    input  logic [ADDR_W-1:WORD_LSB]     addr_word,
    output logic [NUM_CORE_BANKS:0]      bank_sel,
    output reg_e                         reg_idx
);
    localparam int NUM_BANKS = NUM_CORE_BANKS + 1;
    localparam int WIN_W     = ADDR_W - BANK_LSB;
    localparam int CORE_WIN  = CORE_BASE >> BANK_LSB;

    logic [WIN_W-1:0] win;

    assign win     = addr_word[ADDR_W-1:BANK_LSB];
    assign reg_idx = reg_e'(addr_word[BANK_LSB-1:WORD_LSB]);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_win
        localparam int BASE_WIN = (b == 0) ? 0 : CORE_WIN + b - 1;
        assign bank_sel[b] = (win == WIN_W'(BASE_WIN));
    end

endmodule

// File: rtl/mbx_bank.sv
module mbx_bank
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  acc_t              acc,
    output logic [MBX_DW-1:0] rdata,
    output logic              host_irq,
    output logic              io_irq
);
    logic [MBX_DW-1:0] host_msg, io_msg;
    ctrl_t             hctl, ictl, hctl_n, ictl_n, wr_ctl;
    logic              wr, h_wr, i_wr;
    logic [MBX_DW-1:0] rd_val;

    assign wr     = acc.wr & sel;
    assign h_wr   = wr && (acc.idx == RG_HCTL);
    assign i_wr   = wr && (acc.idx == RG_ICTL) && acc.is_io;
    assign wr_ctl = ctrl_of(acc.wdata[CTRL_BITS-1:0]);

    // next state: clear first, then hardware set on top so sets win
    always_comb begin
        hctl_n = hctl;
        ictl_n = ictl;
        if (h_wr) begin
            hctl_n.cmd  = wr_ctl.cmd;
            hctl_n.en   = wr_ctl.en;
            hctl_n.stat = hctl.stat & ~wr_ctl.stat;
        end
        if (i_wr) begin
            ictl_n.en   = wr_ctl.en;
            ictl_n.stat = ictl.stat & ~wr_ctl.stat;
        end
        if (i_wr) hctl_n.stat = hctl_n.stat | wr_ctl.cmd;
        if (h_wr) ictl_n.stat = ictl_n.stat | wr_ctl.cmd;
        ictl_n.cmd = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            host_msg <= '0;
            io_msg   <= '0;
            hctl     <= '0;
            ictl     <= '0;
        end else begin
            if (wr && acc.idx == RG_HMSG) host_msg <= acc.wdata;
            if (wr && acc.idx == RG_IMSG) io_msg   <= acc.wdata;
            hctl <= hctl_n;
            ictl <= ictl_n;
        end
    end

    always_comb begin
        unique case (acc.idx)
            RG_HMSG: rd_val = host_msg;
            RG_HCTL: rd_val = ctrl_word(hctl);
            RG_IMSG: rd_val = io_msg;
            RG_ICTL: rd_val = acc.is_io ? ctrl_word(ictl) : '0;
            default: rd_val = '0;
        endcase
    end

    assign rdata    = sel ? rd_val : '0;
    assign host_irq = |(hctl.stat & hctl.en);
    assign io_irq   = |(ictl.stat & ictl.en);

endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell
    import mbx_pkg::*;
#(
    parameter int ADDR_W         = 11,
    parameter int NUM_CORE_BANKS = 3,
    parameter int CORE_BASE      = 'h400
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  logic              is_io,
    input  logic [ADDR_W-1:0] addr,
    input  logic [MBX_DW-1:0] wdata,
    output logic [MBX_DW-1:0] rdata,
    output logic              host_irq,
    output logic              io_irq
);
    localparam int NUM_BANKS = NUM_CORE_BANKS + 1;

    logic [NUM_BANKS-1:0]  bank_sel;
    logic [NUM_BANKS-1:0]  host_v, io_v;
    logic [MBX_DW-1:0]     bank_rd [NUM_BANKS];
    logic [MBX_DW-1:0]     rd_any;
    reg_e                  reg_idx;
    acc_t                  acc;
    logic                  unused_addr_lsb;

    assign unused_addr_lsb = ^addr[WORD_LSB-1:0];

    mbx_decode #(
        .ADDR_W         (ADDR_W),
        .NUM_CORE_BANKS (NUM_CORE_BANKS),
        .CORE_BASE      (CORE_BASE)
    ) u_dec (
        .addr_word (addr[ADDR_W-1:WORD_LSB]),
        .bank_sel  (bank_sel),
        .reg_idx   (reg_idx)
    );

    assign acc.wr    = req & we;
    assign acc.is_io = is_io;
    assign acc.idx   = reg_idx;
    assign acc.wdata = wdata;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        mbx_bank u_bank (
            .clk      (clk),
            .rst      (rst),
            .sel      (bank_sel[b]),
            .acc      (acc),
            .rdata    (bank_rd[b]),
            .host_irq (host_v[b]),
            .io_irq   (io_v[b])
        );
    end

    always_comb begin
        rd_any = '0;
        for (int b = 0; b < NUM_BANKS; b++) rd_any = rd_any | bank_rd[b];
    end

    assign rdata    = (req && !we) ? rd_any : '0;
    assign host_irq = |host_v;
    assign io_irq   = |io_v;

endmodule

// File: rtl/mbx_doorbell_chk.sv
module mbx_doorbell_chk #(
    parameter int ADDR_W         = 11,
    parameter int NUM_CORE_BANKS = 3,
    parameter int CORE_BASE      = 'h400
) (
    input logic              clk,
    input logic              rst,
    input logic              req,
    input logic              we,
    input logic              is_io,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata,
    input logic              host_irq,
    input logic              io_irq
);
    localparam int CORE_WIN = CORE_BASE >> 4;

    int   win;
    logic mapped;
    logic unused_chk;

    assign unused_chk = ^wdata;
    assign win        = int'(addr[ADDR_W-1:4]);
    assign mapped     = (win == 0) || (win >= CORE_WIN && win < CORE_WIN + NUM_CORE_BANKS);

    // R10: reset leaves both interrupt lines low
    a_r10_reset_quiet: assert property (@(posedge clk)
        rst |=> (!host_irq && !io_irq));

    // R7: host reads of an I/O control word return zero
    a_r7_host_ictl_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (req && !we && !is_io && addr[3:2] == 2'd3) |-> (rdata == 32'd0));

    // R9: unmapped reads return zero
    a_r9_unmapped_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (req && !we && !mapped) |-> (rdata == 32'd0));

    // R8: host interrupt only changes after a bus write
    a_r8_host_irq_rise_after_write: assert property (@(posedge clk) disable iff (rst)
        ($rose(host_irq) || $fell(host_irq)) |-> $past(req && we));

    // R8: I/O interrupt only changes after a bus write
    a_r8_io_irq_change_after_write: assert property (@(posedge clk) disable iff (rst)
        ($rose(io_irq) || $fell(io_irq)) |-> $past(req && we));

    // R9: a write to an unmapped offset moves neither interrupt
    a_r9_unmapped_write_inert: assert property (@(posedge clk) disable iff (rst)
        (req && we && !mapped) |=> ($stable(host_irq) && $stable(io_irq)));

endmodule

bind mbx_doorbell mbx_doorbell_chk #(
    .ADDR_W         (ADDR_W),
    .NUM_CORE_BANKS (NUM_CORE_BANKS),
    .CORE_BASE      (CORE_BASE)
) u_chk (.*);

// File: tb/mbx_doorbell_test.sv
module mbx_doorbell_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic        is_io = 1'b0;
    logic [10:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        host_irq, io_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic HOST = 1'b0;
    localparam logic IOP  = 1'b1;

    always #2 clk = ~clk;   // 250 MHz

    mbx_doorbell uut (
        .clk(clk), .rst(rst), .req(req), .we(we), .is_io(is_io),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .host_irq(host_irq), .io_irq(io_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic m, input logic [10:0] a, input logic [31:0] d);
        @(negedge clk);
        req = 1'b1; we = 1'b1; is_io = m; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic m, input logic [10:0] a, output logic [31:0] d);
        @(negedge clk);
        req = 1'b1; we = 1'b0; is_io = m; addr = a;
        #1 d = rdata;
        req = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic m, input logic [10:0] a,
                          input logic [31:0] exp);
        logic [31:0] v;
        rd(m, a, v);
        chk(tag, v, exp);
    endtask

    function automatic logic [10:0] base(input int k);
        return (k == 0) ? 11'h000 : 11'(32'h400 + (k - 1) * 16);
    endfunction

    task automatic t_reset;
        for (int k = 0; k < 4; k++)
            for (int r = 0; r < 4; r++)
                rd_chk("R10 reset register", IOP, base(k) + 11'(r * 4), 32'd0);
        chk("R10 host_irq after reset", {31'd0, host_irq}, 32'd0);
        chk("R10 io_irq after reset", {31'd0, io_irq}, 32'd0);
    endtask

    task automatic t_messages;
        for (int k = 0; k < 4; k++) begin
            wr(HOST, base(k) + 11'h0, 32'hA500_0000 | k);
            wr(IOP,  base(k) + 11'h8, 32'h5A00_0000 | (k << 8));
        end
        for (int k = 0; k < 4; k++) begin
            rd_chk("R2 host message via I/O", IOP, base(k) + 11'h0, 32'hA500_0000 | k);
            rd_chk("R2 I/O message via host", HOST, base(k) + 11'h8, 32'h5A00_0000 | (k << 8));
        end
        rd_chk("R1 low address bits ignored", HOST, 11'h403, 32'hA500_0001);
        rd_chk("R1 core bank 2 message", IOP, 11'h420 + 11'h8, 32'h5A00_0300);
    endtask

    task automatic t_host_ctrl;
        wr(HOST, 11'h004, 32'hFFFF_FFFF);
        rd_chk("R3 host control fields", HOST, 11'h004, 32'h0000_0033);
        rd_chk("R4 commands set I/O pending", IOP, 11'h00C, 32'h0000_000C);
        chk("R8 io_irq low without enable", {31'd0, io_irq}, 32'd0);
        wr(IOP, 11'h00C, 32'h0000_000C);
        rd_chk("R6 I/O pending cleared", IOP, 11'h00C, 32'd0);
        wr(HOST, 11'h004, 32'h0);
        rd_chk("R3 host control cleared", HOST, 11'h004, 32'd0);
        rd_chk("R4 zero command sets nothing", IOP, 11'h00C, 32'd0);
    endtask

    task automatic t_doorbell;
        wr(IOP, 11'h41C, 32'h30);
        chk("R8 io_irq enable alone", {31'd0, io_irq}, 32'd0);
        wr(HOST, 11'h414, 32'h01);
        chk("R8 io_irq on doorbell", {31'd0, io_irq}, 32'd1);
        rd_chk("R4 pending bit 2", IOP, 11'h41C, 32'h34);
        wr(IOP, 11'h41C, 32'h30);
        rd_chk("R6 zero write keeps pending", IOP, 11'h41C, 32'h34);
        chk("R8 io_irq level held", {31'd0, io_irq}, 32'd1);
        wr(IOP, 11'h41C, 32'h34);
        chk("R8 io_irq drops on clear", {31'd0, io_irq}, 32'd0);
        wr(HOST, 11'h414, 32'h02);
        rd_chk("R4 pending bit 3", IOP, 11'h41C, 32'h38);
        chk("R8 io_irq on second doorbell", {31'd0, io_irq}, 32'd1);
        wr(IOP, 11'h41C, 32'h38);
        rd_chk("R6 pending bit 3 cleared", IOP, 11'h41C, 32'h30);
        chk("R8 io_irq low again", {31'd0, io_irq}, 32'd0);
        wr(HOST, 11'h414, 32'h0);
        wr(IOP, 11'h41C, 32'h0);
    endtask

    task automatic t_reply;
        wr(HOST, 11'h424, 32'h10);
        wr(IOP, 11'h42C, 32'h01);
        rd_chk("R5 reply sets host status 2", HOST, 11'h424, 32'h14);
        chk("R8 host_irq on reply", {31'd0, host_irq}, 32'd1);
        rd_chk("R5 trigger bits read zero", IOP, 11'h42C, 32'h0);
        wr(HOST, 11'h424, 32'h10);
        rd_chk("R6 zero write keeps status", HOST, 11'h424, 32'h14);
        wr(HOST, 11'h424, 32'h14);
        chk("R6 host_irq drops on clear", {31'd0, host_irq}, 32'd0);
        wr(IOP, 11'h42C, 32'h02);
        rd_chk("R5 ack sets host status 3", HOST, 11'h424, 32'h18);
        chk("R8 masked status no irq", {31'd0, host_irq}, 32'd0);
        wr(HOST, 11'h424, 32'h20);
        chk("R8 enabling pending status raises irq", {31'd0, host_irq}, 32'd1);
        wr(HOST, 11'h424, 32'h08);
        rd_chk("R6 host control clear", HOST, 11'h424, 32'h0);
        chk("R8 host_irq low", {31'd0, host_irq}, 32'd0);
    endtask

    task automatic t_access;
        wr(IOP, 11'h40C, 32'h30);
        wr(HOST, 11'h404, 32'h01);
        chk("R8 io_irq before host attempt", {31'd0, io_irq}, 32'd1);
        wr(HOST, 11'h40C, 32'h3F);
        rd_chk("R7 host write ignored", IOP, 11'h40C, 32'h34);
        chk("R7 io_irq unchanged", {31'd0, io_irq}, 32'd1);
        rd_chk("R7 host triggers ignored", HOST, 11'h404, 32'h01);
        rd_chk("R7 host read returns zero", HOST, 11'h40C, 32'h0);
        wr(IOP, 11'h40C, 32'h34);
        chk("R8 io_irq cleared by I/O", {31'd0, io_irq}, 32'd0);
        wr(HOST, 11'h404, 32'h0);
    endtask

    task automatic t_unmapped;
        wr(HOST, 11'h010, 32'hDEAD_BEEF);
        wr(IOP,  11'h3F0, 32'hDEAD_BEEF);
        wr(IOP,  11'h430, 32'hDEAD_BEEF);
        wr(HOST, 11'h7FC, 32'hDEAD_BEEF);
        rd_chk("R9 unmapped 0x010", HOST, 11'h010, 32'h0);
        rd_chk("R9 unmapped 0x430", IOP, 11'h430, 32'h0);
        rd_chk("R9 unmapped 0x7FC", IOP, 11'h7FC, 32'h0);
        rd_chk("R9 legacy message intact", HOST, 11'h000, 32'hA500_0000);
        rd_chk("R9 core bank 0 message intact", IOP, 11'h408, 32'h5A00_0100);
        chk("R9 no interrupt", {30'd0, host_irq, io_irq}, 32'd0);
    endtask

    task automatic t_read_gate;
        logic [31:0] v;
        @(negedge clk);
        req = 1'b1; we = 1'b1; is_io = HOST; addr = 11'h000; wdata = 32'hA500_0000;
        #1 v = rdata;
        chk("R11 rdata zero during write", v, 32'h0);
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        #1 v = rdata;
        chk("R11 rdata zero without request", v, 32'h0);
        rd_chk("R11 same-cycle read data", IOP, 11'h000, 32'hA500_0000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset;
        t_messages;
        t_host_ctrl;
        t_doorbell;
        t_reply;
        t_access;
        t_unmapped;
        t_read_gate;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule